// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

The controller gathers 48 level-sensitive interrupt request lines, masks each with its own enable bit, and picks the single winner among the lines that are both requesting and enabled. The higher line index always wins. Line 0 has no source attached in normal use. A global enable input gates the single request sent to the processor.

When the processor takes the interrupt, it reads the vector byte at offset 00h of a small 16-bit register bus. That read is the acknowledge. The byte is 10h plus the index of the winning line. If no line wins at the moment of the read, for example because the request dropped before the acknowledge, the byte is 10h. Software treats 10h as a spurious interrupt.

The same bus also gives write and read-back access to the enable words, and read access to the raw request levels.

Top module: `prio_irq_ctrl`

## Requirements
- R1: `cpu_irq` is high in the same cycle if and only if `gie` is high and at least one line has both its request and its enable bit set.
- R2: Among the lines that are requesting and enabled, the line with the highest index wins.
- R3: A read at offset 0h returns the vector in bits 7:0, equal to 10h plus the winning index (range 10h to 3Fh), with bits 15:8 zero.
- R4: If no line is both requesting and enabled when offset 0h is read, the vector is 10h.
- R5: The enable words are at 0Ah (lines 0-15), 0Ch (lines 16-31) and 0Eh (lines 32-47), with bit n of a word mapping to line 16*k+n. They reset to zero, take a write on the next clock edge, and read back what was written.
- R6: Offsets 02h, 04h and 06h return the raw request levels of lines 0-15, 16-31 and 32-47, whatever the enables hold. Writes to these offsets have no effect.
- R7: Read data is registered. It appears on `bus_rdata` after the clock edge that samples the read, reflects the inputs in that cycle, and holds until the next read. It is zero after reset.
- R8: A read of any other offset returns zero, and a write to any other offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_req | input | 48 | Level-sensitive request lines, index 0 to 47 |
| gie | input | 1 | Global enable for maskable interrupts |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
A corrupted enable bit shows in two places. It changes `cpu_irq` in the very cycle its line requests. It also shows on the next read of the matching enable word, one edge after the read strobe.

A fault in the priority chain or the vector adder only shows at an acknowledge read. The bench therefore reads offset 0h under patterns where two enabled lines compete, where the top line is masked, and where nothing is enabled. Each of these results is visible one edge after the strobe.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int          NUM_SRC  = 48,
  parameter logic [7:0]  VEC_BASE = 8'h10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [3:0]         bus_addr,
  input  logic [15:0]        bus_wdata,
  output logic [15:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               gie,
  output logic               cpu_irq
);
  localparam int NWORD  = NUM_SRC / 16;
  localparam int IDX_W  = $clog2(NUM_SRC);
  localparam int ST_OFF = 2;
  localparam int EN_OFF = 10;

  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] act;
  logic [IDX_W-1:0]   win_idx;
  logic [7:0]         vec;
  logic [15:0]        rd_mux;

  assign act     = irq_req & en_q;
  assign cpu_irq = gie && (|act);

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (act[i]) win_idx = IDX_W'(i);
  end

  assign vec = VEC_BASE + 8'(win_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else if (bus_sel && bus_wr)
      for (int w = 0; w < NWORD; w++)
        if (int'(bus_addr) == EN_OFF + 2*w) en_q[w*16 +: 16] <= bus_wdata;
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == 4'h0) rd_mux = {8'h00, vec};
    for (int w = 0; w < NWORD; w++) begin
      if (int'(bus_addr) == ST_OFF + 2*w) rd_mux = irq_req[w*16 +: 16];
      if (int'(bus_addr) == EN_OFF + 2*w) rd_mux = en_q[w*16 +: 16];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int         NUM_SRC  = 48,
  parameter logic [7:0] VEC_BASE = 8'h10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [3:0]         bus_addr,
  input logic [15:0]        bus_rdata,
  input logic [NUM_SRC-1:0] irq_req,
  input logic [NUM_SRC-1:0] en_q,
  input logic               gie,
  input logic               cpu_irq
);
  logic rd0;
  assign rd0 = bus_sel && !bus_wr && bus_addr == 4'h0;

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !cpu_irq); // R1

  AST_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && irq_req[NUM_SRC-1] && en_q[NUM_SRC-1]) |=> bus_rdata == {8'h00, VEC_BASE + 8'(NUM_SRC-1)}); // R2

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd0 |=> (bus_rdata[15:8] == 8'h00 && bus_rdata[7:0] >= VEC_BASE && bus_rdata[7:0] <= VEC_BASE + 8'(NUM_SRC-1))); // R3

  AST_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && (irq_req & en_q) == '0) |=> bus_rdata == {8'h00, VEC_BASE}); // R4

  AST_STATUS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 4'h2) |=> bus_rdata == $past(irq_req[15:0])); // R6

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata)); // R7
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE)) u_chk (.*);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [47:0] irq_req = '0;
  logic        gie = 0;
  logic        cpu_irq;
  int          n_run = 0, n_fail = 0;
  logic [47:0] en_m = '0;
  logic        done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
    if (a == 4'hA) en_m[15:0] = d;
    if (a == 4'hC) en_m[31:16] = d;
    if (a == 4'hE) en_m[47:32] = d;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0;
    d = bus_rdata;
  endtask

  function automatic logic [15:0] model_vec(logic [47:0] r, logic [47:0] e);
    logic [7:0] v = 8'h10;
    for (int i = 0; i < 48; i++) if (r[i] && e[i]) v = 8'h10 + 8'(i);
    return {8'h00, v};
  endfunction

  task automatic t_reset();
    logic [15:0] d;
    chk("R7 rdata after reset", bus_rdata, 16'h0);
    gie = 1; irq_req = '1; #1;
    chk("R5 no irq with reset enables", 16'(cpu_irq), 16'h0);
    rd(4'hC, d); chk("R5 enable word reset", d, 16'h0);
    irq_req = '0;
  endtask

  task automatic t_enable_rw();
    logic [15:0] d;
    wr(4'hA, 16'hA5A5); wr(4'hC, 16'h1234); wr(4'hE, 16'hF00F);
    rd(4'hA, d); chk("R5 enable 0Ah readback", d, 16'hA5A5);
    rd(4'hC, d); chk("R5 enable 0Ch readback", d, 16'h1234);
    rd(4'hE, d); chk("R5 enable 0Eh readback", d, 16'hF00F);
  endtask

  task automatic t_status();
    logic [15:0] d;
    irq_req = 48'h8001_4242_C3C3;
    rd(4'h2, d); chk("R6 status 02h", d, 16'hC3C3);
    rd(4'h4, d); chk("R6 status 04h", d, 16'h4242);
    rd(4'h6, d); chk("R6 status 06h", d, 16'h8001);
    wr(4'h2, 16'h0000);
    rd(4'h2, d); chk("R6 write to status ignored", d, 16'hC3C3);
    irq_req = '0;
  endtask

  task automatic t_priority();
    logic [15:0] d;
    wr(4'hA, 16'hFFFF); wr(4'hC, 16'hFFFF); wr(4'hE, 16'hFFFF);
    irq_req = '0; irq_req[3] = 1; irq_req[20] = 1;
    rd(4'h0, d); chk("R2 line 20 beats 3", d, model_vec(irq_req, en_m));
    chk("R3 vector 24h", d, 16'h0024);
    irq_req = '0; irq_req[47] = 1; irq_req[5] = 1;
    rd(4'h0, d); chk("R3 top line vector 3Fh", d, 16'h003F);
    irq_req = '0; irq_req[1] = 1;
    rd(4'h0, d); chk("R3 lowest real line 11h", d, 16'h0011);
    wr(4'hE, 16'h7FFF);
    irq_req = '0; irq_req[47] = 1; irq_req[9] = 1;
    rd(4'h0, d); chk("R2 masked top line skipped", d, 16'h0019);
  endtask

  task automatic t_spurious();
    logic [15:0] d;
    irq_req = '0;
    rd(4'h0, d); chk("R4 no request gives 10h", d, 16'h0010);
    wr(4'hA, 16'h0000);
    irq_req = '0; irq_req[4] = 1;
    rd(4'h0, d); chk("R4 masked request gives 10h", d, 16'h0010);
    irq_req = '0;
  endtask

  task automatic t_gie();
    irq_req = '0; irq_req[30] = 1; gie = 0; #1;
    chk("R1 gie low blocks irq", 16'(cpu_irq), 16'h0);
    gie = 1; #1;
    chk("R1 gie high passes irq", 16'(cpu_irq), 16'h1);
    irq_req = '0; #1;
    chk("R1 no request no irq", 16'(cpu_irq), 16'h0);
  endtask

  task automatic t_unmapped_hold();
    logic [15:0] d;
    wr(4'h8, 16'hFFFF);
    rd(4'h8, d); chk("R8 unmapped reads zero", d, 16'h0);
    rd(4'hA, d); chk("R8 unmapped write changes nothing", d, 16'h0000);
    irq_req = 48'h0000_0000_5555;
    rd(4'h2, d);
    irq_req = 48'h0000_0000_AAAA;
    @(negedge clk); @(negedge clk);
    chk("R7 rdata holds between reads", bus_rdata, 16'h5555);
    irq_req = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_enable_rw();
    t_status();
    t_priority();
    t_spurious();
    t_gie();
    t_unmapped_hold();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule